// File: doc/BRIEF.md
# Supply Phase and Standby Sequencer

This block is the digital sequencer for an off-line switching controller. It steps the controller through three supply phases: charging the supply capacitor from the high-voltage start-up source, switching, and a latched-off wait while the supply capacitor drains. Each phase change is driven by comparator flags that say whether the supply is above its start (about 13 V), turn-off (about 10 V) and restart (about 6.5 V) thresholds.

Alongside the phases it keeps two single-bit memories. The first records how the most recent on-time ended: no over-current (NOC) or over-current (OC). The second is a standby mode bit set from that record. When the standby bit is set, the block turns on the standby current source on the sense pin. While latched off it also connects the control pin to its standby clamp, which gives hiccup or pulsed standby operation.

Two kinds of protection gate switching. Over-voltage and quick OVP hold switching off until the next start-up. Over-temperature holds switching off between a trip flag and a release flag. All comparator flags pass through two-flop synchronisers. The on-time end strobe arrives in the clock domain from the PWM core.

Top module: `supply_phase_seq`

## Requirements
- R1: After reset the phase is START and both memories are cleared. The outputs are `hv_src_en`=1 and `sw_en`, `sby_isrc_en`, `clamp_sby`, `clamp_shunt` all 0.
- R2: In START the phase moves to RUN when `vcc_gt_start` is 1, and stays in START otherwise. In RUN, `hv_src_en`=0, `clamp_shunt`=1, and `sw_en`=1 when no protection is active.
- R3: RUN moves to HOLD when `vcc_gt_off` is 0. HOLD moves to START when `vcc_gt_restart` is 0. In HOLD, `hv_src_en`, `sw_en`, `sby_isrc_en` and `clamp_shunt` are all 0.
- R4: A change on a comparator flag that is set up before a rising edge reaches the outputs after the third rising edge, and not after the second.
- R5: A 1 on `vcc_ovp` or `qovp_cur` forces `sw_en` to 0. It stays 0 after the flag clears, and is released only when HOLD moves to START.
- R6: A pulse on `on_end` stores `on_noc` (1 = NOC, 0 = OC) in the working record only while the phase is RUN. A pulse in any other phase is ignored.
- R7: When RUN moves to HOLD with the record holding NOC, the standby bit is set. `clamp_sby` is then 1 in that HOLD, and `sby_isrc_en` is 1 in the following START and RUN.
- R8: When HOLD moves to START with the record holding OC, the standby bit is cleared, so `sby_isrc_en` is 0 in that START and the next RUN.
- R9: `dmg_gt_recfg`=1 during RUN clears the standby bit. This clear takes priority over the set of R7 on the RUN-to-HOLD transition.
- R10: `ot_trip`=1 forces `sw_en` to 0 until `ot_release` is 1. A release with no prior trip has no effect. If both flags are 1 together, the trip wins.
- R11: `clamp_shunt` is 1 only in RUN, and `clamp_sby` is 1 only in HOLD with the standby bit set. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_gt_start | input | 1 | Supply above start threshold |
| vcc_gt_off | input | 1 | Supply above switching turn-off threshold |
| vcc_gt_restart | input | 1 | Supply above restart threshold |
| vcc_ovp | input | 1 | Supply over-voltage comparator |
| qovp_cur | input | 1 | Demag-pin current above the quick OVP level |
| dmg_gt_recfg | input | 1 | Demag-pin current above the reconfiguration level (secondary back to normal) |
| ot_trip | input | 1 | Die temperature above trip point |
| ot_release | input | 1 | Die temperature below trip point minus hysteresis |
| on_end | input | 1 | One-cycle strobe at the end of each on-time |
| on_noc | input | 1 | With `on_end`: 1 = ended without over-current, 0 = over-current |
| hv_src_en | output | 1 | High-voltage start-up source enable |
| sw_en | output | 1 | Switching enable to the PWM core |
| sby_isrc_en | output | 1 | Standby current source on the sense pin |
| clamp_sby | output | 1 | Control pin connected to standby clamp |
| clamp_shunt | output | 1 | Control pin connected to shunt regulator |

## Verification
The hardest condition to reach from the ports is a standby bit that has been set and must then be cleared by one of two competing paths. Reaching it takes a full hiccup cycle: start-up, a switching phase ending with a NOC strobe, the drop to HOLD, and the next start-up. The stimulus drives that cycle through the supply flags. It then replays the cycle three ways: with the reconfiguration flag raised as RUN exits, with an OC strobe before the exit, and with a strobe arriving outside RUN. This separates the R9 priority, the R8 clear and the R6 gating, each observed on `sby_isrc_en` and `clamp_sby` in the phases that follow.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int FL_VST  = 0;
    localparam int FL_VOFF = 1;
    localparam int FL_VRS  = 2;
    localparam int FL_OVP  = 3;
    localparam int FL_QOVP = 4;
    localparam int FL_DMG  = 5;
    localparam int FL_OTT  = 6;
    localparam int FL_OTR  = 7;
    localparam int FL_N    = 8;

    typedef enum logic [2:0] {
        PH_START = 3'b001,
        PH_RUN   = 3'b010,
        PH_HOLD  = 3'b100
    } phase_t;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= g_stage[i-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/sps_phase_fsm.sv
module sps_phase_fsm
    import sps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   vst,
    input  logic   voff,
    input  logic   vrs,
    output phase_t phase,
    output logic   to_hold,
    output logic   to_start
);
    phase_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_START;
        else        phase <= nxt;
    end

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_START: if (vst)   nxt = PH_RUN;
            PH_RUN:   if (!voff) nxt = PH_HOLD;
            PH_HOLD:  if (!vrs)  nxt = PH_START;
            default:             nxt = PH_START;
        endcase
    end

    assign to_hold  = (phase == PH_RUN)  && !voff;
    assign to_start = (phase == PH_HOLD) && !vrs;

    assert_run_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START && vst) |=> (phase == PH_RUN));
    assert_start_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START && !vst) |=> (phase == PH_START));
    assert_hold_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && !vrs) |=> (phase == PH_START));
    assert_run_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && !voff) |=> (phase == PH_HOLD));
endmodule

// File: rtl/sps_mode_ctl.sv
module sps_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_run,
    input  logic to_hold,
    input  logic to_start,
    input  logic end_vld,
    input  logic end_noc,
    input  logic dmg_hi,
    output logic mode_sby
);
    logic work_noc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                work_noc <= 1'b0;
        else if (end_vld && in_run) work_noc <= end_noc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    mode_sby <= 1'b0;
        else if (in_run && dmg_hi)     mode_sby <= 1'b0;
        else if (to_hold && work_noc)  mode_sby <= 1'b1;
        else if (to_start && !work_noc) mode_sby <= 1'b0;
    end

    assert_record_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(end_vld && in_run) |=> $stable(work_noc));
    assert_mode_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (to_hold && work_noc && !dmg_hi) |=> mode_sby);
    assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (to_start && !work_noc) |=> !mode_sby);
    assert_recfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && dmg_hi) |=> !mode_sby);
endmodule

// File: rtl/sps_guard.sv
module sps_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic ovp,
    input  logic qovp,
    input  logic to_start,
    input  logic ot_trip,
    input  logic ot_rel,
    output logic fault,
    output logic hot
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           fault <= 1'b0;
        else if (ovp || qovp) fault <= 1'b1;
        else if (to_start)    fault <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hot <= 1'b0;
        else if (ot_trip) hot <= 1'b1;
        else if (ot_rel)  hot <= 1'b0;
    end

    assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !to_start) |=> fault);
    assert_fault_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp || qovp) |=> fault);
    assert_hot_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hot && !ot_rel) |=> hot);
    assert_trip_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip |=> hot);
endmodule

// File: rtl/supply_phase_seq.sv
module supply_phase_seq
    import sps_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_gt_start,
    input  logic vcc_gt_off,
    input  logic vcc_gt_restart,
    input  logic vcc_ovp,
    input  logic qovp_cur,
    input  logic dmg_gt_recfg,
    input  logic ot_trip,
    input  logic ot_release,
    input  logic on_end,
    input  logic on_noc,
    output logic hv_src_en,
    output logic sw_en,
    output logic sby_isrc_en,
    output logic clamp_sby,
    output logic clamp_shunt
);
    logic [FL_N-1:0] raw_fl;
    logic [FL_N-1:0] fl;
    phase_t          phase;
    logic            to_hold;
    logic            to_start;
    logic            mode_sby;
    logic            fault;
    logic            hot;
    logic            in_run;

    always_comb begin
        raw_fl          = '0;
        raw_fl[FL_VST]  = vcc_gt_start;
        raw_fl[FL_VOFF] = vcc_gt_off;
        raw_fl[FL_VRS]  = vcc_gt_restart;
        raw_fl[FL_OVP]  = vcc_ovp;
        raw_fl[FL_QOVP] = qovp_cur;
        raw_fl[FL_DMG]  = dmg_gt_recfg;
        raw_fl[FL_OTT]  = ot_trip;
        raw_fl[FL_OTR]  = ot_release;
    end

    sps_sync #(.W(FL_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_fl),
        .q     (fl)
    );

    sps_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vst      (fl[FL_VST]),
        .voff     (fl[FL_VOFF]),
        .vrs      (fl[FL_VRS]),
        .phase    (phase),
        .to_hold  (to_hold),
        .to_start (to_start)
    );

    assign in_run = (phase == PH_RUN);

    sps_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_run   (in_run),
        .to_hold  (to_hold),
        .to_start (to_start),
        .end_vld  (on_end),
        .end_noc  (on_noc),
        .dmg_hi   (fl[FL_DMG]),
        .mode_sby (mode_sby)
    );

    sps_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovp      (fl[FL_OVP]),
        .qovp     (fl[FL_QOVP]),
        .to_start (to_start),
        .ot_trip  (fl[FL_OTT]),
        .ot_rel   (fl[FL_OTR]),
        .fault    (fault),
        .hot      (hot)
    );

    always_comb begin
        hv_src_en   = 1'b0;
        sw_en       = 1'b0;
        sby_isrc_en = 1'b0;
        clamp_sby   = 1'b0;
        clamp_shunt = 1'b0;
        unique case (phase)
            PH_START: begin
                hv_src_en   = 1'b1;
                sby_isrc_en = mode_sby;
            end
            PH_RUN: begin
                sw_en       = !fault && !hot;
                sby_isrc_en = mode_sby;
                clamp_shunt = 1'b1;
            end
            PH_HOLD: begin
                clamp_sby   = mode_sby;
            end
            default: begin
                hv_src_en   = 1'b0;
            end
        endcase
    end

    assert_prot_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hot || fault) |-> !sw_en);
    assert_clamp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(clamp_sby && clamp_shunt));
    assert_src_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hv_src_en |-> !sw_en);
endmodule

// File: tb/supply_phase_seq_bench.sv
module supply_phase_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vst = 0, voff = 0, vrs = 0, ovp = 0, qovp = 0, dmg = 0;
    logic ott = 0, otr = 0, on_end = 0, on_noc = 0;
    logic hv, sw, sby, csby, cshunt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [4:0] exp_q[$];
    string      tag_q[$];
    event       chk_ev;

    // obs bit order: {hv_src_en, sw_en, sby_isrc_en, clamp_sby, clamp_shunt}
    localparam logic [4:0] O_START  = 5'b10000;
    localparam logic [4:0] O_STARTS = 5'b10100;
    localparam logic [4:0] O_RUN    = 5'b01001;
    localparam logic [4:0] O_RUNS   = 5'b01101;
    localparam logic [4:0] O_RUNOFF = 5'b00001;
    localparam logic [4:0] O_HOLD   = 5'b00000;
    localparam logic [4:0] O_HOLDS  = 5'b00010;

    always #5 clk = ~clk;

    supply_phase_seq u_supply_phase_seq (
        .clk(clk), .rst_n(rst_n),
        .vcc_gt_start(vst), .vcc_gt_off(voff), .vcc_gt_restart(vrs),
        .vcc_ovp(ovp), .qovp_cur(qovp), .dmg_gt_recfg(dmg),
        .ot_trip(ott), .ot_release(otr),
        .on_end(on_end), .on_noc(on_noc),
        .hv_src_en(hv), .sw_en(sw), .sby_isrc_en(sby),
        .clamp_sby(csby), .clamp_shunt(cshunt)
    );

    // monitor: pops expectations and compares against outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [4:0] e;
                string r;
                e = exp_q.pop_front();
                r = tag_q.pop_front();
                checks++;
                if ({hv, sw, sby, csby, cshunt} !== e) begin
                    errors++;
                    $display("FAIL %s: outputs %b expected %b", r,
                             {hv, sw, sby, csby, cshunt}, e);
                end
            end
        end
    end

    task automatic expect_now(input logic [4:0] e, input string r);
        exp_q.push_back(e);
        tag_q.push_back(r);
        ->chk_ev;
        #1;
    endtask

    task automatic expect_out(input logic [4:0] e, input string r);
        repeat (4) @(posedge clk);
        @(negedge clk);
        expect_now(e, r);
    endtask

    task automatic strobe(input logic noc);
        @(negedge clk);
        on_end = 1'b1;
        on_noc = noc;
        @(negedge clk);
        on_end = 1'b0;
    endtask

    task automatic go_run(input logic [4:0] e, input string r);
        @(negedge clk);
        vrs = 1; voff = 1; vst = 1;
        expect_out(e, r);
        @(negedge clk);
        vst = 0;
    endtask

    task automatic go_hold(input logic [4:0] e, input string r);
        @(negedge clk);
        voff = 0;
        expect_out(e, r);
    endtask

    task automatic go_start(input logic [4:0] e, input string r);
        @(negedge clk);
        vrs = 0;
        expect_out(e, r);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        expect_out(O_START, "R1 reset state");
        @(negedge clk); vrs = 1; voff = 1;
        expect_out(O_START, "R2 waits below start");
        go_run(O_RUN, "R2 start to run");
        expect_out(O_RUN, "R2 run held after start flag drops");

        strobe(1'b0);
        go_hold(O_HOLD, "R3 run to hold normal");
        go_start(O_START, "R3 hold to start");

        // enter standby: NOC at end of on-time
        go_run(O_RUN, "R2 second run");
        strobe(1'b1);
        go_hold(O_HOLDS, "R7 R11 standby clamp in hold");
        go_start(O_STARTS, "R7 standby source in start");
        go_run(O_RUNS, "R7 standby source in run");

        // strobe outside RUN is ignored
        go_hold(O_HOLDS, "R7 hold again");
        strobe(1'b0);
        go_start(O_STARTS, "R6 strobe in hold ignored");
        go_run(O_RUNS, "R6 run still standby");

        // reconfiguration current clears mode and beats set
        @(negedge clk); dmg = 1;
        expect_out(O_RUN, "R9 recfg clears mode in run");
        go_hold(O_HOLD, "R9 clear beats set at exit");
        @(negedge clk); dmg = 0;
        go_start(O_START, "R9 start normal after clear");
        go_run(O_RUN, "R9 run normal");
        go_hold(O_HOLDS, "R7 set again from NOC record");
        go_start(O_STARTS, "R7 start standby");
        go_run(O_RUNS, "R7 run standby");
        strobe(1'b0);
        expect_out(O_RUNS, "R6 OC stored in run");
        go_hold(O_HOLDS, "R7 mode kept in hold");
        go_start(O_START, "R8 OC record clears mode at start");
        go_run(O_RUN, "R8 next run normal");

        // over-voltage and quick OVP
        @(negedge clk); ovp = 1;
        expect_out(O_RUNOFF, "R5 ovp disables switching");
        @(negedge clk); ovp = 0;
        expect_out(O_RUNOFF, "R5 ovp latched");
        go_hold(O_HOLD, "R5 hold");
        go_start(O_START, "R5 start");
        go_run(O_RUN, "R5 released after start");
        @(negedge clk); qovp = 1;
        repeat (2) @(negedge clk);
        qovp = 0;
        expect_out(O_RUNOFF, "R5 quick ovp latched");
        go_hold(O_HOLD, "R5 hold after qovp");
        go_start(O_START, "R5 start after qovp");
        go_run(O_RUN, "R5 run after qovp");

        // thermal
        @(negedge clk); otr = 1;
        expect_out(O_RUN, "R10 release alone no effect");
        @(negedge clk); otr = 0; ott = 1;
        expect_out(O_RUNOFF, "R10 trip disables");
        @(negedge clk); ott = 0;
        expect_out(O_RUNOFF, "R10 stays off after trip clears");
        @(negedge clk); ott = 1; otr = 1;
        expect_out(O_RUNOFF, "R10 trip wins over release");
        @(negedge clk); ott = 0;
        expect_out(O_RUN, "R10 release re-enables");
        @(negedge clk); otr = 0;
        expect_out(O_RUN, "R10 stays on");

        // latency
        @(negedge clk); voff = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect_now(O_RUN, "R4 not yet after two edges");
        @(posedge clk);
        @(negedge clk);
        expect_now(O_HOLD, "R4 changed after third edge");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule